// File: doc/BRIEF.md
# Dual Sprite Graphics Shifter

This block keeps the graphics bytes of two independent sprites and turns each into a serial pixel stream. Each sprite has a two-stage byte buffer: a fresh stage and a held stage. A CPU write to either sprite loads its fresh stage. On the same edge, the other sprite's fresh byte moves into that other sprite's held stage. A program can therefore prepare one sprite's byte while the other sprite's earlier byte stays frozen. Per sprite, a delay control chooses which stage is shown, and a mirror control chooses the bit scan direction.

A start pulse rewinds a sprite's 3-bit scan counter and arms it. A per-sprite pixel enable steps the counter through eight pixels. After eight pixels the output stays low until the next start pulse. Mirroring uses the same counter: the decoder reads either its true or its inverted outputs. Each pixel bit is registered once before it leaves the block.

The write port is a plain strobe. A write is taken on every cycle in which the strobe is high, with no back-pressure and no ready signal.

Top module: `dual_sprite_shifter`

## Requirements
- R1: On a rising edge with `wr_en` high, the fresh stage of the sprite named by `wr_sel` (0 or 1) takes `wr_data`.
- R2: On that same edge, the other sprite's held stage takes the other sprite's fresh byte as it stood before the edge.
- R3: A write to a sprite leaves that sprite's own held stage unchanged.
- R4: `delay_sel[s]` = 0 shows sprite s's fresh stage; `delay_sel[s]` = 1 shows its held stage.
- R5: A high `px_start[s]` sets sprite s's scan position to pixel 0 and arms the scan. When `px_en[s]` is high in the same cycle, the start pulse wins.
- R6: An armed scan advances one pixel per edge on which `px_en[s]` is high. While `px_en[s]` is low, it holds, and the same pixel bit repeats.
- R7: With `mirror[s]` = 0, the eight pixels come out as byte bits 7, 6, ..., 0, most significant bit first.
- R8: With `mirror[s]` = 1, the eight pixels come out as byte bits 0, 1, ..., 7.
- R9: After the eighth pixel, `pix_out[s]` is 0 until the next start pulse.
- R10: A synchronous reset (`rst` high at an edge) clears all four stages and both scan counters, and drives `pix_out` to 0.
- R11: `pix_out[s]` is registered. The pixel for a scan position appears on the edge after the one that set that position, so the first pixel follows the start edge by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | CPU write strobe |
| wr_sel | input | 1 | Sprite written: 0 or 1 |
| wr_data | input | 8 | Graphics byte written |
| delay_sel | input | 2 | Per sprite: 1 shows the held stage, 0 shows the fresh stage |
| mirror | input | 2 | Per sprite: 1 scans bit 0 first |
| px_en | input | 2 | Per sprite pixel advance enable |
| px_start | input | 2 | Per sprite scan start pulse |
| pix_out | output | 2 | Per sprite registered pixel bit |

## Verification
A write takes effect at the edge that samples it. The first pixel of a scan is due one edge after the start edge, and pixel i is due i+1 edges after it. The output returns to 0 at the ninth edge after the start edge. The bench drives and samples 1 ns after each rising edge and keeps count of edges from every stimulus. Stage contents are observed only through scans with the matching `delay_sel` setting.

// File: rtl/sprite_pkg.sv
package sprite_pkg;
  localparam int SPR_N = 2;

  typedef enum logic {
    SHOW_FRESH = 1'b0,
    SHOW_HELD  = 1'b1
  } stage_pick_e;
endpackage

// File: rtl/sprite_stages.sv
module sprite_stages #(
  parameter int W = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic                              wr_sel,
  input  logic [W-1:0]                      wr_data,
  output logic [sprite_pkg::SPR_N-1:0][W-1:0] fresh_q,
  output logic [sprite_pkg::SPR_N-1:0][W-1:0] held_q
);
  for (genvar g = 0; g < sprite_pkg::SPR_N; g++) begin : g_spr
    localparam logic MY_ID = (g == 1);
    localparam int   PEER  = sprite_pkg::SPR_N - 1 - g;
    logic [W-1:0] fresh_r, held_r;

    // own write loads fresh; peer write moves fresh into held
    always_ff @(posedge clk) begin
      if (rst) begin
        fresh_r <= '0;
        held_r  <= '0;
      end else if (wr_en) begin
        if (wr_sel == MY_ID) fresh_r <= wr_data;
        else                 held_r  <= fresh_r;
      end
    end

    assign fresh_q[g] = fresh_r;
    assign held_q[g]  = held_r;
    if (PEER < 0) begin : g_never
    end
  end
endmodule

// File: rtl/scan_counter.sv
module scan_counter #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             adv,
  output logic [IDX_W-1:0] cnt,
  output logic             active
);
  localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (start) begin
      cnt    <= '0;
      active <= 1'b1;
    end else if (adv && active) begin
      if (cnt == LAST) begin
        cnt    <= '0;
        active <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bit_picker.sv
module bit_picker #(
  parameter int W     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     gfx,
  input  logic [IDX_W-1:0] cnt,
  input  logic             mirror,
  input  logic             active,
  output logic             pix
);
  logic [IDX_W-1:0] idx;
  logic [W-1:0]     sel;
  logic             pix_d;

  // mirror takes the counter's inverted outputs
  assign idx = mirror ? ~cnt : cnt;

  // index 0 selects the top bit
  for (genvar b = 0; b < W; b++) begin : g_dec
    localparam logic [IDX_W-1:0] HIT = IDX_W'(W - 1 - b);
    assign sel[b] = (idx == HIT);
  end

  assign pix_d = active & (|(sel & gfx));

  always_ff @(posedge clk) begin
    if (rst) pix <= 1'b0;
    else     pix <= pix_d;
  end
endmodule

// File: rtl/dual_sprite_shifter.sv
module dual_sprite_shifter #(
  parameter int GFX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [GFX_W-1:0] wr_data,
  input  logic [1:0]       delay_sel,
  input  logic [1:0]       mirror,
  input  logic [1:0]       px_en,
  input  logic [1:0]       px_start,
  output logic [1:0]       pix_out
);
  import sprite_pkg::*;
  localparam int IDX_W = $clog2(GFX_W);

  logic [SPR_N-1:0][GFX_W-1:0] stage_new, stage_old, shown;
  logic [SPR_N-1:0][IDX_W-1:0] scan_cnt;
  logic [SPR_N-1:0]            scan_act;

  sprite_stages #(.W(GFX_W)) u_stages (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .fresh_q(stage_new), .held_q(stage_old)
  );

  for (genvar g = 0; g < SPR_N; g++) begin : g_lane
    assign shown[g] = (stage_pick_e'(delay_sel[g]) == SHOW_HELD) ? stage_old[g] : stage_new[g];

    scan_counter #(.IDX_W(IDX_W)) u_cnt (
      .clk(clk), .rst(rst), .start(px_start[g]), .adv(px_en[g]),
      .cnt(scan_cnt[g]), .active(scan_act[g])
    );

    bit_picker #(.W(GFX_W), .IDX_W(IDX_W)) u_pick (
      .clk(clk), .rst(rst), .gfx(shown[g]), .cnt(scan_cnt[g]),
      .mirror(mirror[g]), .active(scan_act[g]), .pix(pix_out[g])
    );
  end
endmodule

// File: rtl/sprite_shifter_chk.sv
module sprite_shifter_chk #(
  parameter int W     = 8,
  parameter int IDX_W = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic                  wr_sel,
  input logic [W-1:0]          wr_data,
  input logic [1:0]            px_en,
  input logic [1:0]            px_start,
  input logic [1:0]            pix_out,
  input logic [1:0][W-1:0]     new_q,
  input logic [1:0][W-1:0]     old_q,
  input logic [1:0][IDX_W-1:0] cnt,
  input logic [1:0]            act
);
  for (genvar g = 0; g < 2; g++) begin : g_chk
    localparam logic ID = (g == 1);
    localparam int   PR = 1 - g;

    a_r1_fresh_load: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == ID) |=> new_q[g] == $past(wr_data));

    a_r2_peer_copy: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == ID) |=> old_q[PR] == $past(new_q[PR]));

    a_r3_own_held_kept: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == ID) |=> $stable(old_q[g]));

    a_r5_start_rewinds: assert property (@(posedge clk) disable iff (rst)
      px_start[g] |=> (cnt[g] == '0) && act[g]);

    a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
      (!px_en[g] && !px_start[g]) |=> $stable(cnt[g]));

    a_r9_dark_after_scan: assert property (@(posedge clk) disable iff (rst)
      !act[g] |=> !pix_out[g]);
  end
endmodule

bind dual_sprite_shifter sprite_shifter_chk #(.W(GFX_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .px_en(px_en), .px_start(px_start), .pix_out(pix_out),
  .new_q(stage_new), .old_q(stage_old), .cnt(scan_cnt), .act(scan_act)
);

// File: tb/tb_dual_sprite_shifter.sv
module tb_dual_sprite_shifter;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en, wr_sel;
  logic [7:0] wr_data;
  logic [1:0] delay_sel, mirror, px_en, px_start, pix_out;
  int checks = 0;
  int errors = 0;

  dual_sprite_shifter dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .delay_sel(delay_sel), .mirror(mirror), .px_en(px_en), .px_start(px_start),
    .pix_out(pix_out)
  );

  always #10 clk = ~clk;

  // {sprite, mirror, data}
  localparam logic [9:0] VEC [6] = '{
    {1'b0, 1'b0, 8'hC4}, {1'b1, 1'b0, 8'h1E}, {1'b0, 1'b1, 8'h80},
    {1'b1, 1'b1, 8'h01}, {1'b0, 1'b1, 8'h3A}, {1'b1, 1'b0, 8'hF0}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic wr(logic s, logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic scan(int s, logic [7:0] d, logic mir, string tag);
    mirror[s]   = mir;
    px_start[s] = 1'b1;
    step();
    px_start[s] = 1'b0;
    chk($sformatf("R11 %s latency s%0d", tag, s), pix_out[s], 1'b0);
    px_en[s] = 1'b1;
    for (int i = 0; i < 8; i++) begin
      step();
      chk($sformatf("%s s%0d pixel %0d", tag, s, i), pix_out[s], mir ? d[i] : d[7-i]);
    end
    step();
    chk($sformatf("R9 %s s%0d dark", tag, s), pix_out[s], 1'b0);
    step();
    chk($sformatf("R9 %s s%0d still dark", tag, s), pix_out[s], 1'b0);
    px_en[s] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    delay_sel = '0; mirror = '0; px_en = '0; px_start = '0;
    repeat (3) step();
    chk("R10 reset pix0", pix_out[0], 1'b0);
    chk("R10 reset pix1", pix_out[1], 1'b0);
    rst = 1'b0;

    // table walk: R1 load, R4 fresh stage, R7/R8 order
    for (int v = 0; v < 6; v++) begin
      wr(VEC[v][9], VEC[v][7:0]);
      delay_sel = 2'b00;
      scan(int'(VEC[v][9]), VEC[v][7:0], VEC[v][8], VEC[v][8] ? "R8 R1 mirror" : "R7 R1 plain");
    end

    // cross-coupled stages: R2, R3, R4
    wr(1'b0, 8'hE1);
    wr(1'b1, 8'h36);  // s0 held <= E1
    wr(1'b0, 8'h4B);  // s1 held <= 36, s0 held kept
    delay_sel = 2'b01;
    scan(0, 8'hE1, 1'b0, "R3 R4 s0 held kept");
    delay_sel = 2'b00;
    scan(0, 8'h4B, 1'b0, "R1 R4 s0 fresh");
    delay_sel = 2'b10;
    scan(1, 8'h36, 1'b0, "R2 R4 s1 held copy");
    wr(1'b1, 8'hD8);  // s0 held <= 4B
    scan(1, 8'h36, 1'b1, "R3 s1 held kept");
    delay_sel = 2'b01;
    scan(0, 8'h4B, 1'b0, "R2 s0 held copy");
    delay_sel = 2'b00;
    scan(1, 8'hD8, 1'b0, "R1 s1 fresh");

    // R6 hold while enable low
    wr(1'b0, 8'hA0);
    mirror = 2'b00;
    px_start[0] = 1'b1; step(); px_start[0] = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R6 hold pixel0", pix_out[0], 1'b1);
    end
    px_en[0] = 1'b1; step(); px_en[0] = 1'b0;
    chk("R6 stepped edge", pix_out[0], 1'b1);
    step(); chk("R6 pixel1", pix_out[0], 1'b0);
    step(); chk("R6 pixel1 held", pix_out[0], 1'b0);

    // R5 start wins over enable
    wr(1'b0, 8'h80);
    px_start[0] = 1'b1; step(); px_start[0] = 1'b0; px_en[0] = 1'b1;
    step(); chk("R5 pixel0", pix_out[0], 1'b1);
    step(); chk("R5 pixel1", pix_out[0], 1'b0);
    px_start[0] = 1'b1; step(); px_start[0] = 1'b0;
    chk("R5 pixel2 at restart", pix_out[0], 1'b0);
    step(); chk("R5 rewound to pixel0", pix_out[0], 1'b1);
    step(); chk("R5 then pixel1", pix_out[0], 1'b0);
    px_en[0] = 1'b0;

    // R10 reset mid-scan clears stages and counters
    wr(1'b0, 8'hFF); wr(1'b1, 8'hFF); wr(1'b0, 8'hFF);
    px_start = 2'b11; step(); px_start = 2'b00; px_en = 2'b11;
    step(); step();
    rst = 1'b1; step(); rst = 1'b0; px_en = 2'b00;
    chk("R10 pix0 after reset", pix_out[0], 1'b0);
    chk("R10 pix1 after reset", pix_out[1], 1'b0);
    step(); chk("R10 counter idle", pix_out[0], 1'b0);
    delay_sel = 2'b00; scan(0, 8'h00, 1'b0, "R10 fresh cleared");
    delay_sel = 2'b11; scan(0, 8'h00, 1'b0, "R10 held cleared");
    scan(1, 8'h00, 1'b0, "R10 s1 held cleared");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule